// File: doc/BRIEF.md
# SPI Client Engine with Address Filtering

This block is the receive and transmit engine of an SPI client. It samples the serial clock, data-in and active-low select lines into the system clock domain, shifts characters of 8 or 9 bits in SPI mode 0 (data captured on the rising clock edge, changed on the falling edge, most significant bit first), and returns data on its serial output. Completed characters go into a two-entry receive buffer that software drains through a pop port. A character that arrives while the buffer is full is lost and raises an overflow flag.

When address framing is switched on, the first character of each transaction is treated as an address. The block compares it with two reference values under one of three rules: masked compare, either of two exact values, or an inclusive range. A transaction whose address fails is ignored until select goes high again. A single configuration write port sets the receiver enable, the match rule, framing, select-fall detection, transmit preload and character size. Turning the receiver on while the block is enabled completes only after a fixed number of cycles, and a busy output covers that interval.

Top module: `spi_addr_client`

## Requirements
- R1: With framing on and match rule code 0, an address is accepted when it equals the address reference in every bit where the auxiliary reference holds 0 (a 1 in the auxiliary reference marks a don't-care bit).
- R2: With match rule code 1, an address is accepted when it equals either the address reference or the auxiliary reference.
- R3: With match rule code 2, an address is accepted when it lies between the auxiliary reference (lower bound) and the address reference (upper bound), both bounds included.
- R4: Match rule code 3 accepts no address. After a rejected address, nothing further in that transaction is stored and the serial output stays 0 until select goes high.
- R5: With framing off, the match rule has no effect and every completed character is stored, the first one included.
- R6: A configuration write with receiver enable 0 turns the receiver off in the next cycle, empties the receive buffer and clears the overflow flag. Characters that complete while the receiver is off are not stored.
- R7: A configuration write with receiver enable 1 while the block enable is low turns the receiver on in the next cycle without raising busy.
- R8: A configuration write with receiver enable 1 while the block enable is high and the receiver is off raises busy for SYNC_CYC cycles. The receiver turns on in the cycle busy falls, and busy and receiver-on are never high together.
- R9: With preload on, a transmit write while select is high loads the shift register at once, so the first character of the next transaction carries that value.
- R10: Character size code 1 selects 9-bit characters. Every other code, the reserved codes 2 to 7 included, selects 8-bit characters, which are stored with bit 8 cleared.
- R11: With select-fall detection on, each high-to-low transition of select gives exactly one single-cycle wake pulse. With detection off, no pulse is given.
- R12: The receive buffer holds two characters and returns them in arrival order. A character that completes while it is full is discarded and sets the overflow flag.
- R13: Without preload, a transmit write goes to a holding register that is sent as the next character after the current one. The current character is the one already in the shift register, which is 0 when nothing was left there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_en | input | 1 | Block enable; SPI activity is ignored while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rx_on | input | 1 | Receiver enable value written |
| cfg_amode | input | 2 | Address match rule (0 mask, 1 pair, 2 range, 3 reserved) |
| cfg_addr_frame | input | 1 | First character of each transaction is an address |
| cfg_low_det | input | 1 | Select-fall wake detection enable |
| cfg_preload | input | 1 | Transmit preload enable |
| cfg_char_sz | input | 3 | Character size code (1 = 9 bits, else 8 bits) |
| match_addr | input | 8 | Address reference (range upper bound) |
| match_aux | input | 8 | Mask, second address, or range lower bound |
| tx_we | input | 1 | Transmit data write strobe |
| tx_data | input | 9 | Transmit data |
| rd_pop | input | 1 | Remove the oldest received character |
| rd_data | output | 9 | Oldest received character |
| rd_valid | output | 1 | Receive buffer is not empty |
| rx_on | output | 1 | Receiver is enabled |
| rx_busy | output | 1 | Receiver enable is still in progress |
| rx_ovf | output | 1 | Receive overflow flag |
| ss_wake | output | 1 | Single-cycle pulse on select falling |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_ss_n | input | 1 | Active-low client select |
| spi_miso | output | 1 | Serial data out |

## Verification
The bench sets up range matches exactly at both bounds and one step outside each. A design that swaps the bounds or uses a strict compare accepts or rejects the wrong edge address. It also checks that a rejected transaction leaves both the buffer and the serial output silent, which catches a filter that latches too late and stores the data byte that follows. The receiver-enable sequence is checked cycle by cycle, so a busy interval off by one, or a direct turn-on while the block is enabled, shows up at once. The overflow and flush checks fill the buffer past two entries and then turn the receiver off, which exposes a buffer that overwrites its oldest entry or keeps a stale flag. Transmit checks compare the first character with preload on and off, which tells apart a design that always loads the holding register at select fall.

// File: rtl/spi_cl_pkg.sv
package spi_cl_pkg;
  typedef enum logic [1:0] {
    AM_MASK  = 2'd0,
    AM_PAIR  = 2'd1,
    AM_RANGE = 2'd2,
    AM_RSVD  = 2'd3
  } amode_t;

  localparam logic [2:0] SZ_NINE = 3'd1;
endpackage

// File: rtl/spi_cl_sync.sv
module spi_cl_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cl_addr_match.sv
module spi_cl_addr_match
  import spi_cl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  amode_t            mode,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [ADDR_W-1:0] ref_aux,
  output logic              hit
);
  always_comb begin
    unique case (mode)
      AM_MASK:  hit = ((addr_in ^ ref_addr) & ~ref_aux) == '0;
      AM_PAIR:  hit = (addr_in == ref_addr) || (addr_in == ref_aux);
      AM_RANGE: hit = (addr_in >= ref_aux) && (addr_in <= ref_addr);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_cl_rxfifo.sv
module spi_cl_rxfifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign valid   = (cnt != '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spi_addr_client.sv
module spi_addr_client
  import spi_cl_pkg::*;
#(
  parameter int CHAR_W   = 9,
  parameter int ADDR_W   = 8,
  parameter int RX_DEPTH = 2,
  parameter int SYNC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              periph_en,
  input  logic              cfg_we,
  input  logic              cfg_rx_on,
  input  logic [1:0]        cfg_amode,
  input  logic              cfg_addr_frame,
  input  logic              cfg_low_det,
  input  logic              cfg_preload,
  input  logic [2:0]        cfg_char_sz,
  input  logic [ADDR_W-1:0] match_addr,
  input  logic [ADDR_W-1:0] match_aux,
  input  logic              tx_we,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              rd_pop,
  output logic [CHAR_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rx_on,
  output logic              rx_busy,
  output logic              rx_ovf,
  output logic              ss_wake,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              spi_miso
);
  localparam int BW = $clog2(CHAR_W);
  localparam int PW = $clog2(SYNC_CYC + 1);

  // synchronized serial inputs
  logic [2:0] pins_s;
  logic ss_q, sck_q, mosi_q, ss_d, sck_d;
  spi_cl_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({spi_ss_n, spi_sck, spi_mosi}), .q(pins_s)
  );
  assign {ss_q, sck_q, mosi_q} = pins_s;

  logic sck_rise, sck_fall, ss_fall, active;
  assign sck_rise = sck_q && !sck_d;
  assign sck_fall = !sck_q && sck_d;
  assign ss_fall  = !ss_q && ss_d;
  assign active   = periph_en && !ss_q;

  // configuration
  amode_t     amode_r;
  logic       frame_r, lowdet_r, preload_r;
  logic [2:0] size_r;
  logic       nine;
  assign nine = (size_r == SZ_NINE);

  // shift engine state
  logic [CHAR_W-1:0] rx_sh, tx_sh, tx_hold;
  logic              tx_full, first_r, drop_r;
  logic [BW-1:0]     bit_cnt, last_bit;
  logic [CHAR_W-1:0] rx_next, char_val;
  logic              char_done, addr_phase, hit, store, buf_full;
  logic [PW-1:0]     pend_cnt;
  logic              flush;

  assign last_bit   = nine ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2);
  assign rx_next    = {rx_sh[CHAR_W-2:0], mosi_q};
  assign char_val   = nine ? rx_next : {1'b0, rx_next[CHAR_W-2:0]};
  assign char_done  = active && sck_rise && (bit_cnt == last_bit);
  assign addr_phase = frame_r && first_r;
  assign store      = char_done && rx_on && !drop_r && (!addr_phase || hit);
  assign flush      = cfg_we && !cfg_rx_on;
  assign rx_busy    = (pend_cnt != '0);

  spi_cl_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .mode(amode_r), .addr_in(char_val[ADDR_W-1:0]),
    .ref_addr(match_addr), .ref_aux(match_aux), .hit(hit)
  );

  spi_cl_rxfifo #(.W(CHAR_W), .DEPTH(RX_DEPTH)) u_rxbuf (
    .clk(clk), .rst(rst), .flush(flush), .push(store), .din(char_val),
    .pop(rd_pop), .dout(rd_data), .valid(rd_valid), .full(buf_full)
  );

  // configuration and receiver enable sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      amode_r <= AM_MASK; frame_r <= 1'b0; lowdet_r <= 1'b0;
      preload_r <= 1'b0; size_r <= '0;
      rx_on <= 1'b0; pend_cnt <= '0; rx_ovf <= 1'b0;
    end else begin
      if (cfg_we) begin
        amode_r   <= amode_t'(cfg_amode);
        frame_r   <= cfg_addr_frame;
        lowdet_r  <= cfg_low_det;
        preload_r <= cfg_preload;
        size_r    <= cfg_char_sz;
      end
      if (flush) begin
        rx_on    <= 1'b0;
        pend_cnt <= '0;
      end else if (cfg_we && cfg_rx_on && !rx_on && pend_cnt == '0) begin
        if (periph_en) pend_cnt <= PW'(SYNC_CYC);
        else           rx_on    <= 1'b1;
      end else if (pend_cnt != '0) begin
        pend_cnt <= pend_cnt - 1'b1;
        if (pend_cnt == PW'(1)) rx_on <= 1'b1;
      end
      if (flush)                 rx_ovf <= 1'b0;
      else if (store && buf_full) rx_ovf <= 1'b1;
    end
  end

  // serial shift engine
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_d <= 1'b1; sck_d <= 1'b0;
      rx_sh <= '0; tx_sh <= '0; tx_hold <= '0; tx_full <= 1'b0;
      bit_cnt <= '0; first_r <= 1'b1; drop_r <= 1'b0;
      spi_miso <= 1'b0; ss_wake <= 1'b0;
    end else begin
      ss_d    <= ss_q;
      sck_d   <= sck_q;
      ss_wake <= ss_fall && lowdet_r;
      if (!active) begin
        bit_cnt <= '0;
        if (ss_q) begin
          first_r <= 1'b1;
          drop_r  <= 1'b0;
        end
      end else begin
        if (sck_rise) begin
          rx_sh   <= rx_next;
          bit_cnt <= char_done ? '0 : bit_cnt + 1'b1;
          if (char_done) begin
            first_r <= 1'b0;
            if (addr_phase && !hit) drop_r <= 1'b1;
          end
        end
        if (sck_fall && !drop_r) begin
          if (bit_cnt == '0) begin
            tx_sh   <= tx_full ? tx_hold : '0;
            tx_full <= 1'b0;
          end else begin
            tx_sh <= {tx_sh[CHAR_W-2:0], 1'b0};
          end
        end
      end
      if (tx_we) begin
        if (preload_r && ss_q) begin
          tx_sh <= tx_data;
        end else begin
          tx_hold <= tx_data;
          tx_full <= 1'b1;
        end
      end
      spi_miso <= active && !drop_r && (nine ? tx_sh[CHAR_W-1] : tx_sh[CHAR_W-2]);
    end
  end
endmodule

// File: rtl/spi_addr_client_chk.sv
module spi_addr_client_chk (
  input logic clk,
  input logic rst,
  input logic periph_en,
  input logic cfg_we,
  input logic cfg_rx_on,
  input logic rd_valid,
  input logic rx_on,
  input logic rx_busy,
  input logic rx_ovf,
  input logic ss_wake
);
  // R6: disable write flushes and clears
  a_r6_flush: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_rx_on) |=> (!rx_on && !rx_busy && !rd_valid && !rx_ovf));

  // R7: direct turn-on while block disabled
  a_r7_direct_on: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_rx_on && !periph_en && !rx_busy) |=> (rx_on && !rx_busy));

  // R8: turn-on while enabled goes through busy
  a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_rx_on && periph_en && !rx_on && !rx_busy) |=> (rx_busy && !rx_on));

  // R8: busy and receiver-on exclusive
  a_r8_busy_excl: assert property (@(posedge clk) disable iff (rst)
    rx_busy |-> !rx_on);

  // R8: busy ends in receiver-on unless cancelled
  a_r8_busy_end: assert property (@(posedge clk) disable iff (rst)
    ($fell(rx_busy) && !$past(cfg_we)) |-> rx_on);

  // R11: wake is a single-cycle pulse
  a_r11_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    ss_wake |=> !ss_wake);

  // R12: overflow only rises while buffer holds data
  a_r12_ovf_full: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> $past(rd_valid));
endmodule

bind spi_addr_client spi_addr_client_chk chk_i (
  .clk(clk), .rst(rst), .periph_en(periph_en), .cfg_we(cfg_we),
  .cfg_rx_on(cfg_rx_on), .rd_valid(rd_valid), .rx_on(rx_on),
  .rx_busy(rx_busy), .rx_ovf(rx_ovf), .ss_wake(ss_wake)
);

// File: tb/spi_addr_client_tb_top.sv
`timescale 1ns/1ps
module spi_addr_client_tb_top;
  localparam int HALF = 8;
  localparam int SYNC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, periph_en = 1'b0;
  logic       cfg_we = 1'b0, cfg_rx_on = 1'b0, cfg_addr_frame = 1'b0;
  logic       cfg_low_det = 1'b0, cfg_preload = 1'b0;
  logic [1:0] cfg_amode = 2'd0;
  logic [2:0] cfg_char_sz = 3'd0;
  logic [7:0] match_addr = 8'h0, match_aux = 8'h0;
  logic       tx_we = 1'b0, rd_pop = 1'b0;
  logic [8:0] tx_data = 9'h0, rd_data;
  logic       rd_valid, rx_on, rx_busy, rx_ovf, ss_wake;
  logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_ss_n = 1'b1, spi_miso;

  int n_chk = 0, n_fail = 0, wake_cnt = 0;
  bit done = 0;

  always @(negedge clk) if (ss_wake) wake_cnt++;

  spi_addr_client #(.SYNC_CYC(SYNC)) dut_i (
    .clk(clk), .rst(rst), .periph_en(periph_en), .cfg_we(cfg_we),
    .cfg_rx_on(cfg_rx_on), .cfg_amode(cfg_amode), .cfg_addr_frame(cfg_addr_frame),
    .cfg_low_det(cfg_low_det), .cfg_preload(cfg_preload), .cfg_char_sz(cfg_char_sz),
    .match_addr(match_addr), .match_aux(match_aux), .tx_we(tx_we), .tx_data(tx_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_valid(rd_valid), .rx_on(rx_on),
    .rx_busy(rx_busy), .rx_ovf(rx_ovf), .ss_wake(ss_wake), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n), .spi_miso(spi_miso)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [1:0] m, input logic [7:0] a,
                                 input logic [7:0] ad, input logic [7:0] ax);
    case (m)
      2'd0:    return ((a ^ ad) & ~ax) == 8'h0;
      2'd1:    return (a == ad) || (a == ax);
      2'd2:    return (a >= ax) && (a <= ad);
      default: return 1'b0;
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit rx, input logic [1:0] am, input bit fr,
                     input bit ld, input bit pl, input logic [2:0] sz);
    cfg_rx_on = rx; cfg_amode = am; cfg_addr_frame = fr;
    cfg_low_det = ld; cfg_preload = pl; cfg_char_sz = sz;
    cfg_we = 1'b1; cyc(1); cfg_we = 1'b0;
  endtask

  task automatic put_tx(input logic [8:0] d);
    tx_data = d; tx_we = 1'b1; cyc(1); tx_we = 1'b0;
  endtask

  task automatic ss_lo();
    spi_ss_n = 1'b0; cyc(HALF);
  endtask

  task automatic ss_hi();
    cyc(HALF); spi_ss_n = 1'b1; cyc(2 * HALF);
  endtask

  task automatic char_io(input int nb, input logic [8:0] din, output logic [8:0] dout);
    dout = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      spi_mosi = din[i];
      cyc(HALF);
      dout[i] = spi_miso;
      spi_sck = 1'b1;
      cyc(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic pop(output logic [8:0] d);
    d = rd_data; rd_pop = 1'b1; cyc(1); rd_pop = 1'b0;
  endtask

  task automatic addr_case(input logic [1:0] m, input logic [7:0] a,
                           input logic [7:0] ad, input logic [7:0] ax);
    logic [8:0] d1, d2, p;
    bit e;
    string tg;
    tg = (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : (m == 2'd2) ? "R3" : "R4";
    e = exp_hit(m, a, ad, ax);
    match_addr = ad; match_aux = ax;
    cfg(1'b1, m, 1'b1, 1'b0, 1'b0, 3'd0);
    put_tx(9'h0C6);
    ss_lo();
    char_io(8, {1'b0, a}, d1);
    char_io(8, 9'h05A, d2);
    ss_hi();
    chk({tg, " stored when matched"}, rd_valid, e);
    if (e) begin
      pop(p); chk({tg, " address entry"}, p, {1'b0, a});
      pop(p); chk({tg, " data entry"}, p, 9'h05A);
      chk({tg, " MISO after match"}, d2, 9'h0C6);
    end else begin
      chk("R4 MISO silent after reject", d2, 9'h000);
    end
    while (rd_valid) pop(p);
  endtask

  initial begin
    logic [8:0] d, p;
    logic [7:0] ad, ax, a, t;
    logic [1:0] m;
    int w0;
    void'($urandom(32'd20240611));
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk("R6 reset rx_on", rx_on, 0);
    chk("R8 reset busy", rx_busy, 0);
    chk("R12 reset valid", rd_valid, 0);
    chk("R12 reset ovf", rx_ovf, 0);
    chk("R4 reset MISO", spi_miso, 0);

    // R7 direct enable while block disabled
    cfg(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0);
    chk("R7 rx_on next cycle", rx_on, 1);
    chk("R7 no busy", rx_busy, 0);
    cfg(1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0);
    chk("R6 rx off", rx_on, 0);

    // R8 sequenced enable
    periph_en = 1'b1;
    cfg(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0);
    chk("R8 busy raised", rx_busy, 1);
    chk("R8 rx still off", rx_on, 0);
    cyc(SYNC - 1);
    chk("R8 busy held", rx_busy, 1);
    chk("R8 rx off while busy", rx_on, 0);
    cyc(1);
    chk("R8 busy released", rx_busy, 0);
    chk("R8 rx on", rx_on, 1);

    // R11 wake with detection on
    w0 = wake_cnt;
    ss_lo(); ss_hi();
    chk("R11 one wake pulse", wake_cnt - w0, 1);

    // R5 framing off, reserved rule, R13 hold without preload
    cfg(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0);
    w0 = wake_cnt;
    put_tx(9'h03C);
    ss_lo();
    char_io(8, 9'h0A1, d);
    chk("R13 first char from empty shift reg", d, 9'h000);
    char_io(8, 9'h0B2, d);
    chk("R13 second char from hold", d, 9'h03C);
    ss_hi();
    chk("R11 no pulse when off", wake_cnt - w0, 0);
    chk("R5 first char stored", rd_valid, 1);
    pop(p); chk("R5 first entry", p, 9'h0A1);
    pop(p); chk("R12 order second entry", p, 9'h0B2);

    // R9 preload
    cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0);
    put_tx(9'h0A5);
    ss_lo();
    char_io(8, 9'h011, d);
    chk("R9 preloaded first char", d, 9'h0A5);
    ss_hi();
    while (rd_valid) pop(p);

    // R10 nine-bit and reserved size
    cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 3'd1);
    put_tx(9'h1A5);
    ss_lo();
    char_io(9, 9'h155, d);
    ss_hi();
    chk("R10 nine-bit MISO", d, 9'h1A5);
    pop(p); chk("R10 nine-bit stored", p, 9'h155);
    cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5);
    ss_lo();
    char_io(8, 9'h0C3, d);
    ss_hi();
    pop(p); chk("R10 reserved size acts as 8", p, 9'h0C3);
    chk("R10 single entry", rd_valid, 0);

    // directed address cases
    addr_case(2'd2, 8'h40, 8'h50, 8'h40);
    addr_case(2'd2, 8'h50, 8'h50, 8'h40);
    addr_case(2'd2, 8'h3F, 8'h50, 8'h40);
    addr_case(2'd2, 8'h51, 8'h50, 8'h40);
    addr_case(2'd0, 8'h5A, 8'h50, 8'h0F);
    addr_case(2'd0, 8'h6A, 8'h50, 8'h0F);
    addr_case(2'd1, 8'h22, 8'h11, 8'h22);
    addr_case(2'd1, 8'h33, 8'h11, 8'h22);
    addr_case(2'd3, 8'h11, 8'h11, 8'h11);

    // random address cases
    for (int k = 0; k < 24; k++) begin
      m  = 2'($urandom_range(0, 3));
      ad = 8'($urandom); ax = 8'($urandom);
      if (m == 2'd2 && ax > ad) begin t = ad; ad = ax; ax = t; end
      case ($urandom_range(0, 4))
        0: a = ad;
        1: a = ax;
        2: a = ax - 8'd1;
        3: a = ad + 8'd1;
        default: a = 8'($urandom);
      endcase
      addr_case(m, a, ad, ax);
    end

    // R12 overflow
    cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
    ss_lo();
    char_io(8, 9'h011, d);
    char_io(8, 9'h022, d);
    char_io(8, 9'h033, d);
    ss_hi();
    chk("R12 overflow flag", rx_ovf, 1);
    pop(p); chk("R12 oldest kept", p, 9'h011);
    pop(p); chk("R12 second kept", p, 9'h022);
    chk("R12 third discarded", rd_valid, 0);

    // R6 flush
    ss_lo(); char_io(8, 9'h044, d); ss_hi();
    chk("R6 entry before flush", rd_valid, 1);
    cfg(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
    chk("R6 buffer emptied", rd_valid, 0);
    chk("R6 overflow cleared", rx_ovf, 0);
    chk("R6 receiver off", rx_on, 0);
    ss_lo(); char_io(8, 9'h055, d); ss_hi();
    chk("R6 nothing stored while off", rd_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule